// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This unit reorders the elements of one vector register under a per-element mask. In pack mode it gathers the elements whose mask bit is set and lays them out side by side from destination element 0 upward, keeping their order, and it reports how many it moved. In spread mode it does the opposite. The lowest source elements, taken in order, go to the set mask positions, and every position with a clear mask bit keeps the value it already had.

A request is one pulse on `start`. That pulse samples the source vector, the prior contents of the destination, the mask, the mode and the active length. The unit then scans one element per clock and raises `done` for a single cycle once every active element has been visited. At that point `dst_vec` and `packed_len` carry the result, and they hold it until the next request is accepted. A new request may arrive in the same cycle as `done`, so operations can run back to back.

Top module: `vmce_unit`

## Requirements
- R1: While reset is held and right after it is released, `busy` and `done` are 0, `packed_len` is 0 and `dst_vec` is all zeros.
- R2: Pack (`mode`=0) writes the set-mask elements in ascending source order into destination elements 0, 1, 2 and so on. Element e occupies bits [e*ELEM_W +: ELEM_W] and mask bit e belongs to element e. Example: mask 8'b10110010 packs elements 1, 4, 5 and 7.
- R3: At `done`, `packed_len` equals the number of set mask bits below the effective length, in both modes, and it never exceeds NUM_ELEM.
- R4: In pack mode, destination elements at or above `packed_len` keep the value given on `prev_vec`.
- R5: Spread (`mode`=1) writes source element k to the position of the k-th set mask bit, counting from the least significant bit.
- R6: In spread mode, destination elements whose mask bit is 0 keep their `prev_vec` value. While idle with no request, `dst_vec` and `packed_len` do not change.
- R7: The effective length is `vec_len`, clamped to NUM_ELEM. Mask bits at or above it have no effect.
- R8: `done` is high for exactly one cycle. It rises N cycles after the cycle in which the request is accepted, where N is the effective length. With a length of 0 it rises in the next cycle.
- R9: `busy` is high from the cycle after acceptance until `done` rises, and it is never high together with `done`. A `start` pulse while `busy` is high is ignored, and so is any input change during that time.
- R10: A `start` pulse in the cycle where `done` is high is accepted. The new operation runs in full and does not disturb the result just reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when not busy |
| mode | input | 1 | 0 = pack, 1 = spread |
| vec_len | input | $clog2(NUM_ELEM+1) | Requested active length |
| mask | input | NUM_ELEM | One bit per element |
| src_vec | input | NUM_ELEM*ELEM_W | Source elements, element 0 lowest |
| prev_vec | input | NUM_ELEM*ELEM_W | Prior destination contents |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| packed_len | output | $clog2(NUM_ELEM+1) | Count of elements moved |
| dst_vec | output | NUM_ELEM*ELEM_W | Destination register |

## Verification
Two events can share a cycle. One is the completion pulse of an operation, the other is the acceptance of the next request. The stimulus table is walked with each new request raised in the very cycle that the previous `done` is observed. Each operation is then judged by its own latency, count and destination against an independent model, and `busy` is checked in the cycle after the chained acceptance. A second overlap is a `start` pulse, with corrupted inputs, raised in the middle of a scan. It is judged by the unchanged latency and result of the running operation.

// File: rtl/vmce_pkg.sv
`timescale 1ns/1ps
package vmce_pkg;

  typedef enum logic {
    VM_PACK   = 1'b0,
    VM_SPREAD = 1'b1
  } vm_op_e;

  // Effective length: the requested length limited to the register size.
  function automatic int unsigned clamp_len(input int unsigned req, input int unsigned n);
    return (req > n) ? n : req;
  endfunction

  // True when the element just visited is the final active one.
  function automatic logic is_final(input int unsigned idx, input int unsigned len);
    return (idx + 1) == len;
  endfunction

endpackage

// File: rtl/vmce_scan_ctrl.sv
`timescale 1ns/1ps
module vmce_scan_ctrl #(
  parameter int NUM_ELEM = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [$clog2(NUM_ELEM+1)-1:0] vec_len,
  output logic                          accept,
  output logic                          step,
  output logic                          scan_last,
  output logic [((NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1)-1:0] idx,
  output logic [$clog2(NUM_ELEM+1)-1:0] eff_len,
  output logic                          busy,
  output logic                          done
);
  import vmce_pkg::*;

  localparam int LEN_W = $clog2(NUM_ELEM + 1);
  localparam int IDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1;

  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] len_q;
  logic             busy_q;
  logic             done_q;

  assign eff_len   = LEN_W'(clamp_len(int'(vec_len), NUM_ELEM));
  assign accept    = start && !busy_q;
  assign step      = busy_q;
  assign scan_last = busy_q && is_final(int'(idx_q), int'(len_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      len_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        idx_q <= '0;
        len_q <= eff_len;
        if (eff_len == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (busy_q) begin
        idx_q <= idx_q + IDX_W'(1);
        if (scan_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign idx  = idx_q;
  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/vmce_elem_store.sv
`timescale 1ns/1ps
module vmce_elem_store #(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          accept,
  input  logic                          step,
  input  logic [((NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1)-1:0] idx,
  input  logic [$clog2(NUM_ELEM+1)-1:0] eff_len,
  input  logic                          mode,
  input  logic [NUM_ELEM-1:0]           mask,
  input  logic [NUM_ELEM*ELEM_W-1:0]    src_vec,
  input  logic [NUM_ELEM*ELEM_W-1:0]    prev_vec,
  output logic [NUM_ELEM-1:0]           elem_wr_en,
  output logic [$clog2(NUM_ELEM+1)-1:0] packed_len,
  output logic [NUM_ELEM*ELEM_W-1:0]    dst_vec
);
  import vmce_pkg::*;

  localparam int LEN_W = $clog2(NUM_ELEM + 1);
  localparam int IDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1;

  logic [ELEM_W-1:0] src_q [NUM_ELEM];
  logic [ELEM_W-1:0] dst_q [NUM_ELEM];
  logic [NUM_ELEM-1:0] mask_q;
  logic [NUM_ELEM-1:0] act_mask;
  vm_op_e            op_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  ptr_idx;
  logic              cur_bit;
  logic [ELEM_W-1:0] wr_data;

  assign ptr_idx = cnt_q[IDX_W-1:0];
  assign cur_bit = mask_q[idx];
  assign wr_data = (op_q == VM_PACK) ? src_q[idx] : src_q[ptr_idx];

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
    assign act_mask[e] = (LEN_W'(e) < eff_len);

    // Pack writes at the running count, spread writes at the scan position.
    assign elem_wr_en[e] = step && cur_bit &&
                           ((op_q == VM_PACK) ? (ptr_idx == IDX_W'(e))
                                              : (idx == IDX_W'(e)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[e] <= '0;
        dst_q[e] <= '0;
      end else if (accept) begin
        src_q[e] <= src_vec[e*ELEM_W +: ELEM_W];
        dst_q[e] <= prev_vec[e*ELEM_W +: ELEM_W];
      end else if (elem_wr_en[e]) begin
        dst_q[e] <= wr_data;
      end
    end

    assign dst_vec[e*ELEM_W +: ELEM_W] = dst_q[e];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      op_q   <= VM_PACK;
      cnt_q  <= '0;
    end else if (accept) begin
      mask_q <= mask & act_mask;
      op_q   <= vm_op_e'(mode);
      cnt_q  <= '0;
    end else if (step && cur_bit) begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  assign packed_len = cnt_q;

endmodule

// File: rtl/vmce_unit.sv
`timescale 1ns/1ps
module vmce_unit #(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          mode,
  input  logic [$clog2(NUM_ELEM+1)-1:0] vec_len,
  input  logic [NUM_ELEM-1:0]           mask,
  input  logic [NUM_ELEM*ELEM_W-1:0]    src_vec,
  input  logic [NUM_ELEM*ELEM_W-1:0]    prev_vec,
  output logic                          busy,
  output logic                          done,
  output logic [$clog2(NUM_ELEM+1)-1:0] packed_len,
  output logic [NUM_ELEM*ELEM_W-1:0]    dst_vec
);
  localparam int LEN_W = $clog2(NUM_ELEM + 1);
  localparam int IDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1;

  logic                accept;
  logic                step;
  logic                scan_last;
  logic [IDX_W-1:0]    scan_idx;
  logic [LEN_W-1:0]    eff_len;
  logic [NUM_ELEM-1:0] elem_wr_en;

  vmce_scan_ctrl #(.NUM_ELEM(NUM_ELEM)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vec_len   (vec_len),
    .accept    (accept),
    .step      (step),
    .scan_last (scan_last),
    .idx       (scan_idx),
    .eff_len   (eff_len),
    .busy      (busy),
    .done      (done)
  );

  vmce_elem_store #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .step       (step),
    .idx        (scan_idx),
    .eff_len    (eff_len),
    .mode       (mode),
    .mask       (mask),
    .src_vec    (src_vec),
    .prev_vec   (prev_vec),
    .elem_wr_en (elem_wr_en),
    .packed_len (packed_len),
    .dst_vec    (dst_vec)
  );

endmodule

// File: rtl/vmce_unit_chk.sv
`timescale 1ns/1ps
module vmce_unit_chk #(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          start,
  input logic                          busy,
  input logic                          done,
  input logic                          scan_last,
  input logic [NUM_ELEM-1:0]           wr_en,
  input logic [$clog2(NUM_ELEM+1)-1:0] packed_len,
  input logic [NUM_ELEM*ELEM_W-1:0]    dst_vec
);
  localparam int LEN_W = $clog2(NUM_ELEM + 1);

  // R2 / R5: at most one destination element is written per cycle.
  p_one_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  // R9: no element is written outside a scan.
  p_no_idle_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (wr_en == '0));

  // R9: busy and done are exclusive.
  p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R8: the end of a scan is always reported.
  p_fall_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8: done lasts one cycle unless a fresh request is taken in it.
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  // R9: a scan that has not reached its last element keeps going.
  p_scan_continues_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scan_last) |=> busy);

  // R3: the count stays within the register size.
  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    packed_len <= LEN_W'(NUM_ELEM));

  // R3: the count moves by at most one per scanned element.
  p_len_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((packed_len == $past(packed_len)) ||
              (packed_len == $past(packed_len) + LEN_W'(1))));

  // R6: idle without a request leaves the result untouched.
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(dst_vec) && $stable(packed_len)));

endmodule

bind vmce_unit vmce_unit_chk #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .scan_last  (scan_last),
  .wr_en      (elem_wr_en),
  .packed_len (packed_len),
  .dst_vec    (dst_vec)
);

// File: tb/vmce_unit_tb.sv
`timescale 1ns/1ps
module vmce_unit_tb;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int LW = $clog2(N + 1);
  localparam int NV = 9;

  // Stimulus table: mode, requested length, mask.
  localparam logic       T_MODE [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam int         T_LEN  [NV] = '{8, 8, 8, 8, 8, 5, 3, 12, 0};
  localparam logic [7:0] T_MASK [NV] = '{8'b10110010, 8'hFF, 8'h00, 8'b10110010, 8'hFF,
                                         8'b11110101, 8'b11111110, 8'h81, 8'hFF};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic            mode_i = 1'b0;
  logic [LW-1:0]   vec_len_i = '0;
  logic [N-1:0]    mask_i = '0;
  logic [N*W-1:0]  src_i = '0;
  logic [N*W-1:0]  prev_i = '0;
  logic            busy;
  logic            done;
  logic [LW-1:0]   packed_len;
  logic [N*W-1:0]  dst_vec;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  vmce_unit #(.NUM_ELEM(N), .ELEM_W(W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .mode       (mode_i),
    .vec_len    (vec_len_i),
    .mask       (mask_i),
    .src_vec    (src_i),
    .prev_vec   (prev_i),
    .busy       (busy),
    .done       (done),
    .packed_len (packed_len),
    .dst_vec    (dst_vec)
  );

  task automatic chk(input bit ok, input string tag, input logic [N*W-1:0] act,
                     input logic [N*W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent model: walk the active mask bits, keep a count of hits.
  task automatic model(input logic m, input int vl, input logic [N-1:0] mk,
                       input logic [N*W-1:0] s, input logic [N*W-1:0] p,
                       output logic [N*W-1:0] d, output int cnt);
    int lim;
    lim = (vl > N) ? N : vl;
    d   = p;
    cnt = 0;
    for (int i = 0; i < lim; i++) begin
      if (mk[i]) begin
        if (!m) d[cnt*W +: W] = s[i*W +: W];
        else    d[i*W +: W]   = s[cnt*W +: W];
        cnt++;
      end
    end
  endtask

  task automatic run_op(input int t, input logic m, input int vl, input logic [N-1:0] mk,
                        input bit poke, input bit chained);
    logic [N*W-1:0] s, p, ed;
    int el, cyc, lim;
    string tg;
    for (int i = 0; i < N; i++) begin
      s[i*W +: W] = 16'((t % 15 + 1) * 16'h1000 + i * 16'h0011);
      p[i*W +: W] = 16'(16'hE000 + t * 16 + i);
    end
    model(m, vl, mk, s, p, ed, el);
    lim = (vl > N) ? N : vl;
    tg = m ? "R5 R6" : "R2 R4";
    if (vl != N) tg = {tg, " R7"};
    if (chained) tg = {tg, " R10"};
    mode_i = m; vec_len_i = LW'(vl); mask_i = mk; src_i = s; prev_i = p;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    if (lim > 0) chk(busy == 1'b1, chained ? "R10 busy after chained start" : "R9 busy after start",
                     {{(N*W-1){1'b0}}, busy}, 1);
    while (!done && cyc < 100) begin
      if (poke && cyc == 3) begin
        start_i = 1'b1; mask_i = ~mk; src_i = ~s; mode_i = ~m; vec_len_i = LW'(1);
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk(cyc < 100, "R8 watchdog: done never seen", cyc, 0);
    chk(cyc == lim, poke ? "R9 R8 latency with start while busy" : "R8 latency",
        cyc, lim);
    chk(packed_len == LW'(el), {"R3 packed_len ", tg}, packed_len, el);
    chk(dst_vec == ed, {"dst ", tg, poke ? " R9" : ""}, dst_vec, ed);
  endtask

  initial begin
    logic [N*W-1:0] held;
    // R1: reset state
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(packed_len == '0, "R1 packed_len after reset", packed_len, 0);
    chk(dst_vec == '0, "R1 dst after reset", dst_vec, 0);

    // Table walk: each request after the first lands in the done cycle (R10).
    for (int t = 0; t < NV; t++) begin
      run_op(t, T_MODE[t], T_LEN[t], T_MASK[t], 1'b0, t > 0);
    end

    // R8 / R6: done drops, result holds while idle.
    held = dst_vec;
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(dst_vec == held, "R6 dst held while idle", dst_vec, held);

    // R9: start pulse with corrupted inputs in the middle of a scan.
    run_op(20, 1'b0, 8, 8'b10110010, 1'b1, 1'b0);
    @(negedge clk);
    run_op(21, 1'b1, 8, 8'b01001101, 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule